// File: doc/BRIEF.md
# Configurable Output Logic Cell Bank

This block is a bank of identical output logic cells, one per output pin of a programmable sum-of-products fabric. Each cell takes the sum term that the array computes for its pin and produces a pin value. A per-cell two-bit mode code chooses two things: whether the pin shows a clocked copy of the sum or the sum itself, and whether the pin is inverted. An enable product term drives the pin's tri-state control, so a pin can be a fixed output, a fixed input, or a bidirectional pin.

Each cell also returns a feedback bit to the array. In registered modes the feedback is the true register state, so the array can build state machines from it. In combinational modes the feedback is the level seen on the pin, so a disabled pin serves as an extra array input.

All cells share one clock and three initialisation sources. An asynchronous reset term clears every register at once. A synchronous preset term sets every register on a rising clock edge. An active-low power-on reset also clears the registers asynchronously. The array and the pad drivers are outside this block.

Top module: `macrocell_bank`

## Requirements
- R1: Mode code 2'b00 (bit 1 = 0 registered, bit 0 = 0 active low): the pin value is the complement of the register, which takes the sum term on each rising clock edge.
- R2: Mode code 2'b01 (registered, active high): the pin value equals the register, which takes the sum term on each rising clock edge.
- R3: Mode code 2'b10 (combinational, active low): the pin value is the complement of the current sum term, with no clock delay.
- R4: Mode code 2'b11 (combinational, active high): the pin value equals the current sum term, with no clock delay.
- R5: In either registered mode the feedback bit equals the true register state, whatever the pin polarity.
- R6: In either combinational mode the feedback bit equals the pin input, whether or not the pin output is enabled.
- R7: The reset term clears every register as soon as it is asserted, without a clock edge.
- R8: The preset term sets every register to 1 at a rising clock edge and leaves the register unchanged between edges.
- R9: When the reset term and the preset term are asserted together, the register is 0 after the clock edge.
- R10: While power-on reset is low, every register reads 0. This holds from the start of time and also when power-on reset is pulsed during operation.
- R11: In every mode the pin output enable of each cell follows that cell's enable term with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all cell registers |
| por_n | input | 1 | Power-on reset, active low, asynchronous clear |
| areset_term | input | 1 | Global reset product term, active high, asynchronous clear |
| spreset_term | input | 1 | Global preset product term, active high, takes effect at clock edge |
| cfg_bits | input | 2*NCELL | Mode code per cell, cell i at bits [2i+1:2i]; bit 1 selects combinational, bit 0 selects active high |
| sum_term | input | NCELL | Sum-of-products value per cell |
| oe_term | input | NCELL | Output enable product term per cell |
| pin_in | input | NCELL | Level seen on each pin |
| pin_out | output | NCELL | Value driven toward each pin |
| pin_oe | output | NCELL | Tri-state enable per pin |
| fb_out | output | NCELL | Feedback bit per cell, returned to the array |

## Verification
The embedded properties check several rules on every clock edge. After an edge without preset, a register holds the sum sampled at the previous edge. A preset sets the register, and an asserted reset term keeps it at 0. In registered modes the feedback agrees with the pin value, taking the polarity into account. Other behaviour can only be shown by the bench's scenarios. These are the immediate clear caused by a reset term raised between clock edges, the priority of reset over preset within one edge, the absence of change before a preset edge, the power-on clear, and the pin-input feedback path in combinational modes. The bench sweeps every mode against every pattern of sum, enable and pin input, with different modes on neighbouring cells.

// File: rtl/mc_pkg.sv
package mc_pkg;
  // Per-cell mode code: bit 1 picks combinational path, bit 0 picks active high
  typedef struct packed {
    logic comb;
    logic act_high;
  } mc_cfg_t;

  localparam int unsigned CFG_W = $bits(mc_cfg_t);
endpackage

// File: rtl/mc_state_reg.sv
module mc_state_reg (
  input  logic clk,
  input  logic por_n,
  input  logic areset_term,
  input  logic spreset_term,
  input  logic d,
  output logic q
);
  logic clr;
  logic armed;

  assign clr = areset_term | ~por_n;

  // Clear beats preset: clear is asynchronous, preset is only sampled at edge
  always_ff @(posedge clk or posedge clr) begin
    if (clr)               q <= 1'b0;
    else if (spreset_term) q <= 1'b1;
    else                   q <= d;
  end

  // Marks that at least one clean edge has passed since the last clear
  always_ff @(posedge clk or posedge clr) begin
    if (clr) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R1 / R2: register follows the sum one edge later
  p_capture_r2: assert property (@(posedge clk) disable iff (clr)
    (armed && !spreset_term) |=> (q == $past(d)))
    else $error("register did not capture sum");

  // R8: preset sets the register at the edge
  p_preset_r8: assert property (@(posedge clk) disable iff (clr)
    (armed && spreset_term) |=> q)
    else $error("preset did not set register");

  // R7: an asserted reset term leaves the register clear at any edge
  p_reset_clear_r7: assert property (@(posedge clk) disable iff (!por_n)
    areset_term |-> (q == 1'b0))
    else $error("reset term did not clear register");
endmodule

// File: rtl/mc_out_path.sv
module mc_out_path
  import mc_pkg::*;
(
  input  mc_cfg_t cfg,
  input  logic    sum,
  input  logic    q,
  input  logic    oe,
  output logic    pin_val,
  output logic    pin_en
);
  logic pre_pol;

  always_comb begin
    pre_pol = cfg.comb ? sum : q;
    pin_val = cfg.act_high ? pre_pol : ~pre_pol;
    pin_en  = oe;
  end
endmodule

// File: rtl/mc_fb_sel.sv
module mc_fb_sel
  import mc_pkg::*;
(
  input  mc_cfg_t cfg,
  input  logic    q,
  input  logic    pin_level,
  output logic    fb
);
  // Registered: true state; combinational: whatever sits on the pin
  assign fb = cfg.comb ? pin_level : q;
endmodule

// File: rtl/macrocell_bank.sv
module macrocell_bank
  import mc_pkg::*;
#(
  parameter int unsigned NCELL = 4
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   areset_term,
  input  logic                   spreset_term,
  input  logic [CFG_W*NCELL-1:0] cfg_bits,
  input  logic [NCELL-1:0]       sum_term,
  input  logic [NCELL-1:0]       oe_term,
  input  logic [NCELL-1:0]       pin_in,
  output logic [NCELL-1:0]       pin_out,
  output logic [NCELL-1:0]       pin_oe,
  output logic [NCELL-1:0]       fb_out
);
  localparam int unsigned CFG_TOTAL = CFG_W * NCELL;

  logic clr_any;
  assign clr_any = areset_term | ~por_n;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    mc_cfg_t cfg;
    logic    q;

    assign cfg = mc_cfg_t'(cfg_bits[CFG_W*i +: CFG_W]);

    mc_state_reg u_reg (
      .clk          (clk),
      .por_n        (por_n),
      .areset_term  (areset_term),
      .spreset_term (spreset_term),
      .d            (sum_term[i]),
      .q            (q)
    );

    mc_out_path u_out (
      .cfg     (cfg),
      .sum     (sum_term[i]),
      .q       (q),
      .oe      (oe_term[i]),
      .pin_val (pin_out[i]),
      .pin_en  (pin_oe[i])
    );

    mc_fb_sel u_fb (
      .cfg       (cfg),
      .q         (q),
      .pin_level (pin_in[i]),
      .fb        (fb_out[i])
    );

    // R5: registered feedback matches pin value undone by polarity
    p_fb_true_q_r5: assert property (@(posedge clk) disable iff (clr_any)
      !cfg.comb |-> (fb_out[i] == (cfg.act_high ? pin_out[i] : ~pin_out[i])))
      else $error("registered feedback disagrees with pin");
  end

  initial begin
    p_cfg_width_r1: assert (CFG_TOTAL == 2 * NCELL)
      else $error("mode field width mismatch");
  end
endmodule

// File: tb/macrocell_bank_tb_top.sv
module macrocell_bank_tb_top;
  localparam int unsigned NC    = 4;
  localparam time         CLK_P = 10;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          areset_term = 1'b0;
  logic          spreset_term = 1'b0;
  logic [2*NC-1:0] cfg_bits = '0;
  logic [NC-1:0] sum_term = '0;
  logic [NC-1:0] oe_term = '0;
  logic [NC-1:0] pin_in = '0;
  logic [NC-1:0] pin_out;
  logic [NC-1:0] pin_oe;
  logic [NC-1:0] fb_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  logic [NC-1:0] qm;

  always #(CLK_P/2) clk = ~clk;

  macrocell_bank #(.NCELL(NC)) dut_i (
    .clk(clk), .por_n(por_n), .areset_term(areset_term),
    .spreset_term(spreset_term), .cfg_bits(cfg_bits), .sum_term(sum_term),
    .oe_term(oe_term), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .fb_out(fb_out)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] mode_of(input int i);
    return cfg_bits[2*i +: 2];
  endfunction

  // checks valid between edges, for combinational paths and enables
  task automatic check_comb();
    for (int i = 0; i < NC; i++) begin
      logic [1:0] m = mode_of(i);
      check("R11 pin_oe", pin_oe[i], oe_term[i]);
      if (m[1]) begin
        check(m[0] ? "R4 comb high" : "R3 comb low", pin_out[i],
              m[0] ? sum_term[i] : ~sum_term[i]);
        check("R6 comb feedback", fb_out[i], pin_in[i]);
      end
    end
  endtask

  task automatic check_reg(input string tag);
    for (int i = 0; i < NC; i++) begin
      logic [1:0] m = mode_of(i);
      if (!m[1]) begin
        check(m[0] ? {tag, " R2 reg high"} : {tag, " R1 reg low"}, pin_out[i],
              m[0] ? qm[i] : ~qm[i]);
        check({tag, " R5 reg feedback"}, fb_out[i], qm[i]);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R10: registers clear under power-on reset, alternating 00 / 01 modes
    cfg_bits = 8'b01_00_01_00;
    sum_term = '1;
    qm = '0;
    repeat (3) @(posedge clk);
    #1 check_reg("R10 power-on");
    @(negedge clk) por_n = 1'b1;

    // Exhaustive sweep: every mode on every cell, every data pattern
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      for (int i = 0; i < NC; i++) cfg_bits[2*i +: 2] = 2'((m + i) % 4);
      for (int v = 0; v < 64; v++) begin
        @(negedge clk);
        sum_term = v[3:0];
        oe_term  = v[5:2] ^ 4'b0110;
        pin_in   = ~v[4:1];
        #1 check_comb();
        @(posedge clk);
        qm = sum_term;
        #1 check_reg("sweep");
      end
    end

    // R8: preset acts only at the edge
    @(negedge clk);
    cfg_bits = 8'b01_00_01_00;
    sum_term = '0;
    @(posedge clk); qm = '0;
    @(negedge clk) spreset_term = 1'b1;
    #2 check_reg("R8 before edge");
    @(posedge clk); qm = '1;
    #1 check_reg("R8 after edge");
    @(negedge clk) spreset_term = 1'b0;

    // R7: reset term clears without a clock edge
    #1 areset_term = 1'b1;
    #1 qm = '0;
    check_reg("R7 async clear");

    // R9: reset wins over preset at the edge
    spreset_term = 1'b1;
    sum_term = '1;
    @(posedge clk);
    #1 check_reg("R9 reset over preset");
    @(negedge clk);
    areset_term = 1'b0;
    spreset_term = 1'b0;
    @(posedge clk); qm = '1;
    #1 check_reg("R2 after release");

    // R10: power-on reset pulsed during operation
    @(negedge clk) por_n = 1'b0;
    #1 qm = '0;
    check_reg("R10 mid-run");
    @(posedge clk);
    #1 check_reg("R10 held");
    @(negedge clk) por_n = 1'b1;
    @(posedge clk); qm = sum_term;
    #1 check_reg("R1 resume");

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule